// File: doc/BRIEF.md
# Coprocessor busy-wait handshake controller

This block sits on the coprocessor side of a tightly coupled processor/coprocessor pipeline and follows one coprocessor instruction at a time from the processor's decode stage into its execute stage. A small timer stands in for the coprocessor's execution unit. Each executed instruction keeps the unit busy for a fixed number of cycles. A later instruction that arrives during that time is told to wait, first on the decode-stage handshake and then on the execute-stage handshake.

While an instruction waits in execute, the block samples the processor's pass signal and late-cancel signal on every cycle. Pass high with no late-cancel keeps the instruction waiting until the unit is free. It then runs for a parameterised number of execute beats and commits. Pass low or late-cancel high, for example because an interrupt was taken, abandons the instruction at once. An abandoned instruction never commits, leaves the timer alone, and the block accepts a new instruction in the very next cycle.

Top module: `cop_stall_ctrl`

## Requirements
- R1: After synchronous active-high reset both handshake codes read ABSENT, cp_commit and cp_drop are low, and the timer is clear, so the first instruction goes straight to GO without waiting.
- R2: Both handshake buses use the code 2'b00 = ABSENT, 2'b01 = WAIT, 2'b10 = GO, 2'b11 = LAST.
- R3: One cycle after a cycle with ins_valid high, hs_dec reads WAIT if the execution unit is busy or the execute stage is occupied, and GO otherwise. With ins_valid low it reads ABSENT. hs_dec never reads LAST.
- R4: An instruction that advances (ins_valid and dec_adv both high) while the unit is busy shows WAIT on hs_exe in every following cycle in which the unit is still busy.
- R5: In every execute-wait cycle, cpu_pass low abandons the instruction. In the next cycle hs_exe reads ABSENT, cp_drop is high for one cycle, and cp_commit stays low.
- R6: late_cancel high during an execute-wait cycle abandons the instruction in the same way as R5, whether pass is high or low.
- R7: When the unit becomes free while pass is high, the instruction shows GO on hs_exe for every execute beat except the last, which shows LAST. There are XFER_BEATS beats in all.
- R8: Pass and late-cancel are also checked on the first execute beat. A failing check there abandons the instruction as in R5.
- R9: The cycle after the LAST beat, cp_commit pulses for one cycle and hs_exe reads ABSENT. The timer then reloads, so an instruction that advances k cycles after the commit pulse waits max(BUSY_CYCLES - k, 0) cycles.
- R10: An abandon changes no state. The timer keeps counting down from the last commit, and a new instruction can advance in the same cycle in which cp_drop is shown.
- R11: An instruction held in decode without advancing, and then withdrawn by dropping ins_valid, leaves hs_exe ABSENT and produces neither a commit nor an abandon.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | A coprocessor instruction occupies the decode stage |
| dec_adv | input | 1 | The decode-stage instruction moves into execute at this edge |
| cpu_pass | input | 1 | Processor allows the instruction to execute (sampled each execute-wait cycle) |
| late_cancel | input | 1 | Processor cancels the execute-stage instruction late |
| hs_dec | output | 2 | Decode-stage handshake code |
| hs_exe | output | 2 | Execute-stage handshake code |
| cp_commit | output | 1 | One-cycle pulse: instruction executed, unit becomes busy |
| cp_drop | output | 1 | One-cycle pulse: instruction abandoned |

## Verification
The bound checker watches, on every cycle, that a WAIT on the execute bus met by a failing pass or by late-cancel is followed by a drop pulse. It also checks that a passing LAST beat is followed by a single-cycle commit, that drop and commit never coincide, and that the decode bus never carries LAST. The length of each wait, which follows from the timer reload and the gap since the last commit, can only be shown by the bench. The bench sweeps the arrival gap against every possible abandon point and abandon cause, then sends a follow-up instruction whose expected wait proves the abandon did not disturb the timer. The decode hold and withdraw case is also covered only by the bench.

// File: rtl/cop_stall_pkg.sv
package cop_stall_pkg;

  // Handshake code shared by the decode and execute buses (R2)
  typedef enum logic [1:0] {
    HS_ABSENT = 2'b00,
    HS_WAIT   = 2'b01,
    HS_GO     = 2'b10,
    HS_LAST   = 2'b11
  } hs_code_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DEC_WAIT = 3'd1,
    ST_EXE_WAIT = 3'd2,
    ST_EXE_GO   = 3'd3,
    ST_ABANDON  = 3'd4
  } cs_state_t;

endpackage

// File: rtl/cop_busy_timer.sv
module cop_busy_timer #(
  parameter int BUSY_CYCLES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);

  localparam int CW = (BUSY_CYCLES < 1) ? 1 : $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/cop_stall_fsm.sv
module cop_stall_fsm
  import cop_stall_pkg::*;
#(
  parameter int XFER_BEATS = 2,
  parameter int BW         = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  input  logic            dec_adv,
  input  logic            pass_ok,
  input  logic            busy,
  output cs_state_t       st_q,
  output cs_state_t       st_nxt,
  output logic [BW-1:0]   beat_nxt,
  output logic            commit_c
);

  localparam logic [BW-1:0] LAST_BEAT = BW'(XFER_BEATS - 1);

  logic [BW-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_nxt;
    end
  end

  // Beat counter only exists when an instruction spans several beats
  generate
    if (XFER_BEATS > 1) begin : g_multi_beat
      always_ff @(posedge clk) begin
        if (rst) begin
          beat_q <= '0;
        end else begin
          beat_q <= beat_nxt;
        end
      end
    end else begin : g_single_beat
      assign beat_q = '0;
    end
  endgenerate

  always_comb begin
    st_nxt   = st_q;
    beat_nxt = beat_q;
    commit_c = 1'b0;
    case (st_q)
      ST_EXE_WAIT: begin
        // pass is re-examined on every waiting cycle; abandon wins over busy clearing
        if (!pass_ok) begin
          st_nxt = ST_ABANDON;
        end else if (!busy) begin
          st_nxt   = ST_EXE_GO;
          beat_nxt = '0;
        end
      end
      ST_EXE_GO: begin
        if ((beat_q == '0) && !pass_ok) begin
          st_nxt = ST_ABANDON;
        end else if (beat_q == LAST_BEAT) begin
          st_nxt   = ST_IDLE;
          commit_c = 1'b1;
        end else begin
          beat_nxt = beat_q + BW'(1);
        end
      end
      default: begin
        // IDLE, DEC_WAIT and ABANDON all accept a new instruction
        beat_nxt = '0;
        if (ins_valid && dec_adv) begin
          st_nxt = busy ? ST_EXE_WAIT : ST_EXE_GO;
        end else if (ins_valid && busy) begin
          st_nxt = ST_DEC_WAIT;
        end else begin
          st_nxt = ST_IDLE;
        end
      end
    endcase
  end

endmodule

// File: rtl/cop_hs_encode.sv
module cop_hs_encode
  import cop_stall_pkg::*;
#(
  parameter int XFER_BEATS = 2,
  parameter int BW         = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  cs_state_t     st_q,
  input  cs_state_t     st_nxt,
  input  logic [BW-1:0] beat_nxt,
  input  logic          ins_valid,
  input  logic          busy,
  input  logic          commit_c,
  output logic [1:0]    hs_dec,
  output logic [1:0]    hs_exe,
  output logic          cp_commit,
  output logic          cp_drop
);

  localparam logic [BW-1:0] LAST_BEAT = BW'(XFER_BEATS - 1);

  hs_code_t dec_nxt;
  hs_code_t exe_nxt;
  logic     occupied;

  assign occupied = (st_q == ST_EXE_WAIT) || (st_q == ST_EXE_GO);

  always_comb begin
    if (!ins_valid) begin
      dec_nxt = HS_ABSENT;
    end else if (busy || occupied) begin
      dec_nxt = HS_WAIT;
    end else begin
      dec_nxt = HS_GO;
    end
  end

  always_comb begin
    case (st_nxt)
      ST_EXE_WAIT: exe_nxt = HS_WAIT;
      ST_EXE_GO:   exe_nxt = (beat_nxt == LAST_BEAT) ? HS_LAST : HS_GO;
      default:     exe_nxt = HS_ABSENT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_dec    <= HS_ABSENT;
      hs_exe    <= HS_ABSENT;
      cp_commit <= 1'b0;
      cp_drop   <= 1'b0;
    end else begin
      hs_dec    <= dec_nxt;
      hs_exe    <= exe_nxt;
      cp_commit <= commit_c;
      cp_drop   <= (st_nxt == ST_ABANDON);
    end
  end

endmodule

// File: rtl/cop_stall_ctrl.sv
module cop_stall_ctrl
  import cop_stall_pkg::*;
#(
  parameter int BUSY_CYCLES = 6,
  parameter int XFER_BEATS  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ins_valid,
  input  logic       dec_adv,
  input  logic       cpu_pass,
  input  logic       late_cancel,
  output logic [1:0] hs_dec,
  output logic [1:0] hs_exe,
  output logic       cp_commit,
  output logic       cp_drop
);

  localparam int BW = (XFER_BEATS > 1) ? $clog2(XFER_BEATS) : 1;

  logic          busy;
  logic          commit_c;
  logic          pass_ok;
  cs_state_t     st_q;
  cs_state_t     st_nxt;
  logic [BW-1:0] beat_nxt;

  assign pass_ok = cpu_pass && !late_cancel;

  cop_busy_timer #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .load(commit_c),
    .busy(busy)
  );

  cop_stall_fsm #(
    .XFER_BEATS(XFER_BEATS),
    .BW        (BW)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ins_valid(ins_valid),
    .dec_adv  (dec_adv),
    .pass_ok  (pass_ok),
    .busy     (busy),
    .st_q     (st_q),
    .st_nxt   (st_nxt),
    .beat_nxt (beat_nxt),
    .commit_c (commit_c)
  );

  cop_hs_encode #(
    .XFER_BEATS(XFER_BEATS),
    .BW        (BW)
  ) u_enc (
    .clk      (clk),
    .rst      (rst),
    .st_q     (st_q),
    .st_nxt   (st_nxt),
    .beat_nxt (beat_nxt),
    .ins_valid(ins_valid),
    .busy     (busy),
    .commit_c (commit_c),
    .hs_dec   (hs_dec),
    .hs_exe   (hs_exe),
    .cp_commit(cp_commit),
    .cp_drop  (cp_drop)
  );

endmodule

// File: rtl/cop_stall_chk.sv
module cop_stall_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_pass,
  input logic       late_cancel,
  input logic [1:0] hs_dec,
  input logic [1:0] hs_exe,
  input logic       cp_commit,
  input logic       cp_drop
);

  p_dec_never_last_r3: assert property (@(posedge clk) disable iff (rst)
    hs_dec != 2'b11);

  p_wait_pass_low_r5: assert property (@(posedge clk) disable iff (rst)
    (hs_exe == 2'b01 && !cpu_pass) |=> cp_drop);

  p_wait_late_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    (hs_exe == 2'b01 && late_cancel) |=> cp_drop);

  p_wait_pass_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (hs_exe == 2'b01 && cpu_pass && !late_cancel) |=> (hs_exe != 2'b00 && !cp_drop));

  p_last_commits_r9: assert property (@(posedge clk) disable iff (rst)
    (hs_exe == 2'b11 && cpu_pass && !late_cancel) |=> cp_commit);

  p_commit_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cp_commit |=> !cp_commit);

  p_drop_clean_r10: assert property (@(posedge clk) disable iff (rst)
    cp_drop |-> (hs_exe == 2'b00 && !cp_commit));

endmodule

bind cop_stall_ctrl cop_stall_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_pass   (cpu_pass),
  .late_cancel(late_cancel),
  .hs_dec     (hs_dec),
  .hs_exe     (hs_exe),
  .cp_commit  (cp_commit),
  .cp_drop    (cp_drop)
);

// File: tb/sim_cop_stall_ctrl.sv
module sim_cop_stall_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TB_BUSY    = 5;
  localparam int TB_XFER    = 2;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ins_valid = 1'b0;
  logic       dec_adv = 1'b0;
  logic       cpu_pass = 1'b1;
  logic       late_cancel = 1'b0;
  logic [1:0] hs_dec;
  logic [1:0] hs_exe;
  logic       cp_commit;
  logic       cp_drop;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cop_stall_ctrl #(
    .BUSY_CYCLES(TB_BUSY),
    .XFER_BEATS (TB_XFER)
  ) u0 (
    .clk        (clk),
    .rst        (rst),
    .ins_valid  (ins_valid),
    .dec_adv    (dec_adv),
    .cpu_pass   (cpu_pass),
    .late_cancel(late_cancel),
    .hs_dec     (hs_dec),
    .hs_exe     (hs_exe),
    .cp_commit  (cp_commit),
    .cp_drop    (cp_drop)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    ins_valid = 1'b0;
    dec_adv   = 1'b0;
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic int wait_len(input int v);
    return (v > 0) ? v : 0;
  endfunction

  // Issue one instruction expected to wait w cycles; abort at wait index a
  // (a == w aborts on the first execute beat, a > w runs to commit).
  task automatic run_instr(input string ctx, input int w, input int a,
                           input int kind, output bit dropped);
    dropped   = 1'b0;
    ins_valid = 1'b1;
    dec_adv   = 1'b1;
    cpu_pass  = 1'b1;
    late_cancel = 1'b0;
    step();
    ins_valid = 1'b0;
    dec_adv   = 1'b0;
    chk({ctx, " R3 decode code at advance"}, hs_dec, (w > 0) ? 1 : 2);
    for (int i = 0; i < w; i++) begin
      chk({ctx, " R4 execute WAIT"}, hs_exe, 1);
      if (i == a) begin
        case (kind)
          0:       begin cpu_pass = 1'b0; late_cancel = 1'b1; end
          1:       cpu_pass = 1'b0;
          default: late_cancel = 1'b1;
        endcase
        step();
        chk({ctx, " R5 R6 drop pulse"}, cp_drop, 1);
        chk({ctx, " R5 R6 execute ABSENT after drop"}, hs_exe, 0);
        chk({ctx, " R5 R6 no commit on drop"}, cp_commit, 0);
        cpu_pass = 1'b1;
        late_cancel = 1'b0;
        dropped = 1'b1;
        return;
      end
      step();
    end
    chk({ctx, " R7 first beat code"}, hs_exe, (TB_XFER > 1) ? 2 : 3);
    if (a == w) begin
      cpu_pass = 1'b0;
      step();
      chk({ctx, " R8 drop on first beat"}, cp_drop, 1);
      chk({ctx, " R8 execute ABSENT"}, hs_exe, 0);
      chk({ctx, " R8 no commit"}, cp_commit, 0);
      cpu_pass = 1'b1;
      dropped = 1'b1;
      return;
    end
    for (int b = 1; b < TB_XFER; b++) begin
      step();
      chk({ctx, " R7 beat code"}, hs_exe, (b == TB_XFER - 1) ? 3 : 2);
    end
    step();
    chk({ctx, " R9 commit pulse"}, cp_commit, 1);
    chk({ctx, " R9 execute ABSENT after commit"}, hs_exe, 0);
    chk({ctx, " R9 no drop on commit"}, cp_drop, 0);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit dr;
    bit dr2;
    int w;
    int w2;

    // R1: reset state
    repeat (3) step();
    chk("R1 hs_dec after reset", hs_dec, 0);
    chk("R1 hs_exe after reset", hs_exe, 0);
    chk("R1 cp_commit after reset", cp_commit, 0);
    chk("R1 cp_drop after reset", cp_drop, 0);
    rst = 1'b0;
    run_instr("R1 first instruction", 0, 99, 0, dr);
    chk("R1 first instruction not dropped", dr, 0);

    // R3 and R11: hold in decode while busy, then withdraw
    ins_valid = 1'b1;
    dec_adv   = 1'b0;
    step();
    chk("R3 decode WAIT while busy", hs_dec, 1);
    step();
    chk("R3 decode WAIT held", hs_dec, 1);
    chk("R11 execute stays ABSENT in decode hold", hs_exe, 0);
    ins_valid = 1'b0;
    step();
    chk("R11 decode ABSENT after withdraw", hs_dec, 0);
    chk("R11 execute ABSENT after withdraw", hs_exe, 0);
    chk("R11 no commit after withdraw", cp_commit, 0);
    chk("R11 no drop after withdraw", cp_drop, 0);
    idle(TB_BUSY + 2);
    ins_valid = 1'b1;
    step();
    chk("R3 decode GO when free", hs_dec, 2);
    ins_valid = 1'b0;
    step();
    chk("R3 decode ABSENT", hs_dec, 0);
    chk("R11 execute ABSENT after free withdraw", hs_exe, 0);

    // Sweep arrival gap against every abandon point and cause
    for (int d = 0; d <= TB_BUSY + 1; d++) begin
      w = wait_len(TB_BUSY - d);
      for (int a = 0; a <= w + 1; a++) begin
        idle(TB_BUSY + 2);
        run_instr("prime", 0, 99, 0, dr);
        idle(d);
        run_instr("R9 sweep", w, a, (a + d) % 3, dr);
        chk("R9 sweep drop outcome", dr, (a <= w) ? 1 : 0);
        if (dr) begin
          w2 = wait_len(TB_BUSY - d - a - 2);
          run_instr("R10 after drop", w2, 99, 0, dr2);
          chk("R10 follow-up commits", dr2, 0);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule